// File: doc/BRIEF.md
# Restartable Two-Dimensional Stream Position Tracker

This block keeps the position of an operand stream laid out as a matrix of rows and columns in memory. It holds three position registers: the address of the first element of the current unit of work, the current row index and the current column index. Rows and columns are both counted from zero. A unit of operation consumes one element in sequential mode. In parallel mode it consumes a configured count, and a unit is never allowed to run past the end of a row.

The position moves only when a unit is reported as committed. If the unit raises an exception, the registers stay where they are and still point at the unit that has to be retried. Software can read the three registers and later write them back through a one-cycle restore port, so an interrupted stream instruction can resume from where it stopped. When the last element of the last row commits, a done flag rises and any further commits are ignored.

Top module: `strm2d_pos`

## Requirements
- R1: Synchronous active-high reset clears cur_base, cur_row and cur_col to 0 and clears done.
- R2: With par_mode=0 and done=0, grant_cnt is 1, and a commit without abort advances cur_col by 1 and cur_base by cfg_elem_stride.
- R3: With par_mode=1, grant_cnt equals par_count (a par_count of 0 is treated as 1) when that fits in the columns left in the row. A commit advances cur_col by grant_cnt and cur_base by cfg_elem_stride*grant_cnt.
- R4: In parallel mode a unit that would cross the end of the row is cut to the remaining columns, so grant_cnt = cfg_row_len - cur_col.
- R5: When a commit consumes the last column of a row, cur_col becomes 0, cur_row increments, and cur_base becomes the row start plus cfg_row_stride. The row start is the address of column 0 of the row just finished.
- R6: A commit with abort high in the same cycle changes nothing. Without commit the position holds.
- R7: A commit that finishes the last row (cur_row = cfg_row_cnt-1) wraps as in R5 and sets done. While done is high, grant_cnt is 0 and commits leave the position and done unchanged.
- R8: rs_load loads cur_base, cur_row and cur_col from rs_base, rs_row and rs_col on the next edge and takes priority over commit. The row start becomes rs_base - rs_col*cfg_elem_stride, and done becomes (rs_row >= cfg_row_cnt).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_row_len | input | CW | Columns per row (at least 1) |
| cfg_row_cnt | input | RW | Number of rows |
| cfg_elem_stride | input | AW | Address step between columns |
| cfg_row_stride | input | AW | Address step between row starts |
| par_mode | input | 1 | 1 = parallel units, 0 = one element per unit |
| par_count | input | NW | Elements per unit in parallel mode |
| commit | input | 1 | Current unit completed |
| abort | input | 1 | Current unit hit an exception |
| rs_load | input | 1 | Restore strobe |
| rs_base | input | AW | Restored address |
| rs_row | input | RW | Restored row index |
| rs_col | input | CW | Restored column index |
| cur_base | output | AW | Address of first element of current unit |
| cur_row | output | RW | Current row index |
| cur_col | output | CW | Current column index |
| grant_cnt | output | NW | Elements the current unit may process |
| done | output | 1 | Stream finished |

## Verification
A sequential walk along the first row, ending in a wrap, separates in-row stepping from the row-start jump. It reproduces the wrap from address 30 at column 3 to address 50 at row 1. A parallel request of three with one column left tells the clamped grant apart from the requested one, and a par_count of zero checks the fallback to one element. Commits held together with abort, commits after done, and a restore in the same cycle as a commit each show whether the right input wins. A restore in mid-row followed by a wrap shows whether the row start is rebuilt from the restored column.

// File: rtl/strm2d_pkg.sv
package strm2d_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_STEP,
    ACT_WRAP,
    ACT_LAST,
    ACT_LOAD
  } act_e;
endpackage

// File: rtl/strm2d_grant.sv
module strm2d_grant #(
  parameter int CW = 8,
  parameter int NW = 4
) (
  input  logic          par_mode,
  input  logic [NW-1:0] par_count,
  input  logic [CW-1:0] row_len,
  input  logic [CW-1:0] col,
  input  logic          done,
  output logic [NW-1:0] grant
);
  localparam int LW = (CW > NW) ? CW + 1 : NW + 1;

  logic [LW-1:0] remain;
  logic [LW-1:0] want;

  always_comb begin
    remain = LW'(row_len) - LW'(col);
    if (!par_mode || par_count == '0) want = LW'(1);
    else                              want = LW'(par_count);
    if (done)               grant = '0;
    else if (want > remain) grant = NW'(remain);
    else                    grant = NW'(want);
  end
endmodule

// File: rtl/strm2d_step.sv
module strm2d_step #(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int RW = 8,
  parameter int NW = 4
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] row_start,
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  input  logic [NW-1:0] grant,
  input  logic [CW-1:0] row_len,
  input  logic [RW-1:0] row_cnt,
  input  logic [AW-1:0] elem_stride,
  input  logic [AW-1:0] row_stride,
  output logic [AW-1:0] step_base,
  output logic [CW-1:0] step_col,
  output logic [AW-1:0] wrap_base,
  output logic [RW-1:0] wrap_row,
  output logic          is_wrap,
  output logic          is_last
);
  logic [CW:0] col_sum;

  always_comb begin
    col_sum   = {1'b0, col} + (CW+1)'(grant);
    is_wrap   = (col_sum >= {1'b0, row_len});
    is_last   = is_wrap && ((row + RW'(1)) >= row_cnt);
    step_base = base + elem_stride * AW'(grant);
    step_col  = col_sum[CW-1:0];
    wrap_base = row_start + row_stride;
    wrap_row  = row + RW'(1);
  end
endmodule

// File: rtl/strm2d_pos.sv
module strm2d_pos
  import strm2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int RW = 8,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_row_len,
  input  logic [RW-1:0] cfg_row_cnt,
  input  logic [AW-1:0] cfg_elem_stride,
  input  logic [AW-1:0] cfg_row_stride,
  input  logic          par_mode,
  input  logic [NW-1:0] par_count,
  input  logic          commit,
  input  logic          abort,
  input  logic          rs_load,
  input  logic [AW-1:0] rs_base,
  input  logic [RW-1:0] rs_row,
  input  logic [CW-1:0] rs_col,
  output logic [AW-1:0] cur_base,
  output logic [RW-1:0] cur_row,
  output logic [CW-1:0] cur_col,
  output logic [NW-1:0] grant_cnt,
  output logic          done
);
  logic [AW-1:0] base_q, rstart_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          done_q;

  logic [AW-1:0] step_base, wrap_base;
  logic [CW-1:0] step_col;
  logic [RW-1:0] wrap_row;
  logic          is_wrap, is_last;
  logic [NW-1:0] grant;
  act_e          act;

  strm2d_grant #(.CW(CW), .NW(NW)) grant_i (
    .par_mode (par_mode),
    .par_count(par_count),
    .row_len  (cfg_row_len),
    .col      (col_q),
    .done     (done_q),
    .grant    (grant)
  );

  strm2d_step #(.AW(AW), .CW(CW), .RW(RW), .NW(NW)) step_i (
    .base       (base_q),
    .row_start  (rstart_q),
    .row        (row_q),
    .col        (col_q),
    .grant      (grant),
    .row_len    (cfg_row_len),
    .row_cnt    (cfg_row_cnt),
    .elem_stride(cfg_elem_stride),
    .row_stride (cfg_row_stride),
    .step_base  (step_base),
    .step_col   (step_col),
    .wrap_base  (wrap_base),
    .wrap_row   (wrap_row),
    .is_wrap    (is_wrap),
    .is_last    (is_last)
  );

  always_comb begin
    if (rs_load)                         act = ACT_LOAD;
    else if (commit && !abort && !done_q) begin
      if (is_last)      act = ACT_LAST;
      else if (is_wrap) act = ACT_WRAP;
      else              act = ACT_STEP;
    end else                             act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      rstart_q <= '0;
      row_q    <= '0;
      col_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      case (act)
        ACT_LOAD: begin
          base_q   <= rs_base;
          rstart_q <= rs_base - cfg_elem_stride * AW'(rs_col);
          row_q    <= rs_row;
          col_q    <= rs_col;
          done_q   <= (rs_row >= cfg_row_cnt);
        end
        ACT_STEP: begin
          base_q <= step_base;
          col_q  <= step_col;
        end
        ACT_WRAP, ACT_LAST: begin
          base_q   <= wrap_base;
          rstart_q <= wrap_base;
          row_q    <= wrap_row;
          col_q    <= '0;
          done_q   <= (act == ACT_LAST);
        end
        default: ;
      endcase
    end
  end

  assign cur_base  = base_q;
  assign cur_row   = row_q;
  assign cur_col   = col_q;
  assign grant_cnt = grant;
  assign done      = done_q;

  // R2: sequential mode always grants a single element
  a_r2_seq_single: assert property (@(posedge clk) disable iff (rst)
    (!par_mode && !done) |-> (grant_cnt == NW'(1)));

  // R4: a grant never runs past the end of the row
  a_r4_grant_in_row: assert property (@(posedge clk) disable iff (rst)
    (!done && (cur_col < cfg_row_len)) |->
      ((grant_cnt != '0) && ((CW+1)'(cur_col) + (CW+1)'(grant_cnt) <= (CW+1)'(cfg_row_len))));

  // R5: consuming the row end returns to column 0 of the next row
  a_r5_row_wrap: assert property (@(posedge clk) disable iff (rst)
    (commit && !abort && !rs_load && !done &&
     ((CW+1)'(cur_col) + (CW+1)'(grant_cnt) == (CW+1)'(cfg_row_len))) |=>
      ((cur_col == '0) && (cur_row == $past(cur_row) + RW'(1))));

  // R6: an aborted unit leaves the position untouched
  a_r6_abort_hold: assert property (@(posedge clk) disable iff (rst)
    (abort && !rs_load) |=>
      ($stable(cur_base) && $stable(cur_row) && $stable(cur_col)));

  // R7: once finished, the stream stays finished and frozen
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !rs_load) |=> (done && $stable(cur_base) && $stable(cur_row)));

  // R8: restore puts the saved address back
  a_r8_restore_base: assert property (@(posedge clk) disable iff (rst)
    rs_load |=> (cur_base == $past(rs_base)) && (cur_col == $past(rs_col)));
endmodule

// File: tb/strm2d_pos_tb.sv
module strm2d_pos_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, CW = 8, RW = 8, NW = 4;

  typedef struct packed {
    logic          pm;
    logic [NW-1:0] pc;
    logic          cm;
    logic          ab;
    logic [NW-1:0] g;
    logic [AW-1:0] b;
    logic [RW-1:0] r;
    logic [CW-1:0] c;
    logic          d;
  } vec_t;

  // config: 4 columns, 3 rows, element stride 5, row stride 35, start 15
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0, 1'b1, 1'b0, 4'd1, 32'd20,  8'd0, 8'd1, 1'b0}, // R2
    '{1'b0, 4'd0, 1'b1, 1'b0, 4'd1, 32'd25,  8'd0, 8'd2, 1'b0}, // R2
    '{1'b0, 4'd0, 1'b1, 1'b1, 4'd1, 32'd25,  8'd0, 8'd2, 1'b0}, // R6 abort
    '{1'b0, 4'd0, 1'b1, 1'b0, 4'd1, 32'd30,  8'd0, 8'd3, 1'b0}, // R2
    '{1'b0, 4'd0, 1'b1, 1'b0, 4'd1, 32'd50,  8'd1, 8'd0, 1'b0}, // R5 wrap
    '{1'b1, 4'd3, 1'b1, 1'b0, 4'd3, 32'd65,  8'd1, 8'd3, 1'b0}, // R3
    '{1'b1, 4'd3, 1'b1, 1'b0, 4'd1, 32'd85,  8'd2, 8'd0, 1'b0}, // R4 + R5
    '{1'b1, 4'd0, 1'b1, 1'b0, 4'd1, 32'd90,  8'd2, 8'd1, 1'b0}, // R3 zero count
    '{1'b0, 4'd0, 1'b0, 1'b0, 4'd1, 32'd90,  8'd2, 8'd1, 1'b0}, // R6 no commit
    '{1'b1, 4'd2, 1'b1, 1'b0, 4'd2, 32'd100, 8'd2, 8'd3, 1'b0}, // R3
    '{1'b1, 4'd7, 1'b1, 1'b0, 4'd1, 32'd120, 8'd3, 8'd0, 1'b1}, // R7 last
    '{1'b0, 4'd0, 1'b1, 1'b0, 4'd0, 32'd120, 8'd3, 8'd0, 1'b1}  // R7 ignored
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [CW-1:0] cfg_row_len = 8'd4;
  logic [RW-1:0] cfg_row_cnt = 8'd3;
  logic [AW-1:0] cfg_elem_stride = 32'd5, cfg_row_stride = 32'd35;
  logic par_mode = 1'b0, commit = 1'b0, abort = 1'b0, rs_load = 1'b0;
  logic [NW-1:0] par_count = '0;
  logic [AW-1:0] rs_base = '0;
  logic [RW-1:0] rs_row = '0;
  logic [CW-1:0] rs_col = '0;
  logic [AW-1:0] cur_base;
  logic [RW-1:0] cur_row;
  logic [CW-1:0] cur_col;
  logic [NW-1:0] grant_cnt;
  logic done;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strm2d_pos #(.AW(AW), .CW(CW), .RW(RW), .NW(NW)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_row_len(cfg_row_len), .cfg_row_cnt(cfg_row_cnt),
    .cfg_elem_stride(cfg_elem_stride), .cfg_row_stride(cfg_row_stride),
    .par_mode(par_mode), .par_count(par_count),
    .commit(commit), .abort(abort),
    .rs_load(rs_load), .rs_base(rs_base), .rs_row(rs_row), .rs_col(rs_col),
    .cur_base(cur_base), .cur_row(cur_row), .cur_col(cur_col),
    .grant_cnt(grant_cnt), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_pos(input string req, input logic [AW-1:0] b, input logic [RW-1:0] r,
                         input logic [CW-1:0] c, input logic d);
    chk({req, " base"}, 64'(cur_base), 64'(b));
    chk({req, " row"},  64'(cur_row),  64'(r));
    chk({req, " col"},  64'(cur_col),  64'(c));
    chk({req, " done"}, 64'(done),     64'(d));
  endtask

  task automatic restore(input logic [AW-1:0] b, input logic [RW-1:0] r,
                         input logic [CW-1:0] c, input logic with_commit);
    @(negedge clk);
    rs_load = 1'b1; rs_base = b; rs_row = r; rs_col = c; commit = with_commit;
    @(posedge clk); #1;
    rs_load = 1'b0; commit = 1'b0;
  endtask

  task automatic seq_commit();
    @(negedge clk);
    par_mode = 1'b0; commit = 1'b1; abort = 1'b0;
    @(posedge clk); #1;
    commit = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_pos("R1 reset", 32'd0, 8'd0, 8'd0, 1'b0);
    rst = 1'b0;

    restore(32'd15, 8'd0, 8'd0, 1'b0);
    chk_pos("R8 start", 32'd15, 8'd0, 8'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      par_mode = VEC[i].pm; par_count = VEC[i].pc;
      commit = VEC[i].cm; abort = VEC[i].ab;
      #1;
      chk($sformatf("R3/R4 grant vec %0d", i), 64'(grant_cnt), 64'(VEC[i].g));
      @(posedge clk); #1;
      commit = 1'b0; abort = 1'b0;
      chk_pos($sformatf("R2-R7 vec %0d", i), VEC[i].b, VEC[i].r, VEC[i].c, VEC[i].d);
    end

    // R8: mid-row restore rebuilds row start (70 - 2*5 = 60)
    restore(32'd70, 8'd1, 8'd2, 1'b0);
    chk_pos("R8 mid-row", 32'd70, 8'd1, 8'd2, 1'b0);
    seq_commit();
    chk_pos("R8 step", 32'd75, 8'd1, 8'd3, 1'b0);
    seq_commit();
    chk_pos("R8 wrap from restored start", 32'd95, 8'd2, 8'd0, 1'b0);

    // R8: restore wins over commit in the same cycle
    restore(32'd200, 8'd0, 8'd1, 1'b1);
    chk_pos("R8 priority", 32'd200, 8'd0, 8'd1, 1'b0);

    // R8: restoring past the last row sets done
    restore(32'd300, 8'd3, 8'd0, 1'b0);
    chk_pos("R8 done", 32'd300, 8'd3, 8'd0, 1'b1);
    #1;
    chk("R7 grant when done", 64'(grant_cnt), 64'd0);

    // R1: reset again clears done and position
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk_pos("R1 re-reset", 32'd0, 8'd0, 8'd0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule